// File: doc/BRIEF.md
# LIN Byte-Field Receiver with Activity Flag

This block receives a single LIN byte field from a serial line that is sampled at sixteen times the bit rate. A strobe input marks each sample instant. The block detects and confirms a start bit, votes each of eight data bits from three samples near the middle of the bit cell, checks the stop bit, and delivers the byte on a valid-only output stream. A status output stays high while a byte field is being received.

Reception stops at once when the receiver is disabled or the LIN task is held in reset. The stop bit can also be cut short: if the line shows a new start pattern late in the stop bit, the current byte is finished at that sample and the next byte begins with no gap. The output stream has no ready input, because a serial line cannot be stalled. The sink must take `rx_data` in the one cycle in which `rx_valid` is high. `rx_data` keeps its value until the next delivery.

Top module: `lin_byte_rx`

## Requirements
- R1: After reset, `rx_valid`, `rx_frame_err` and `rx_active` are 0 and `rx_data` is 0x00.
- R2: A start pattern is one high sample followed by three low samples on successive strobes. The third low sample counts as start-bit sample 3. With `rx_en`=1 and `task_rst`=0, the pattern raises `rx_active` in the clock after that strobe. A low run of one or two samples raises nothing.
- R3: At start-bit sample 7, if at least two of start samples 5, 6 and 7 are high, reception is abandoned. `rx_active` falls and no byte is delivered.
- R4: Data arrives LSB first as 8 bits with no parity. Each bit value is the majority of samples 7, 8 and 9 of its 16-sample cell, so a single wrong sample among them does not change the bit.
- R5: If the majority of stop-bit samples 7, 8 and 9 is low, `rx_frame_err` is 1 in the same cycle as `rx_valid`; otherwise it is 0.
- R6: With no start pattern completed at stop sample 10 or later, reception ends at stop sample 16. `rx_valid` is high for exactly one cycle and `rx_active` falls in that same cycle.
- R7: A start pattern that completes at stop sample 10 through 16 ends the byte at that sample, with `rx_valid` high for one cycle. `rx_active` stays high. That sample becomes start sample 3 of the next byte.
- R8: A start pattern that completes before stop sample 10 has no effect: the byte still ends at stop sample 16.
- R9: While `rx_en`=0 or `task_rst`=1, `rx_active` is 0 from the next clock. Any byte in progress is dropped without `rx_valid`, and no start pattern is accepted.
- R10: `rx_data` changes only in a cycle where `rx_valid` is 1 and holds between deliveries. No strobe and no line activity alters it otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Serial line, idle high, synchronised inside |
| sample_tick | input | 1 | One-cycle strobe at 16x the bit rate |
| rx_en | input | 1 | Receiver enable |
| task_rst | input | 1 | LIN task reset, active high |
| rx_data | output | 8 | Last received byte |
| rx_valid | output | 1 | One-cycle delivery strobe for `rx_data` |
| rx_frame_err | output | 1 | Stop bit voted low, qualifies `rx_valid` |
| rx_active | output | 1 | Byte-field reception in progress |

## Verification
The bench builds the block with its defaults: 16x oversampling, 8 data bits, two synchroniser stages and a three-sample start pattern. It drives one strobe every four clocks, which gives the synchroniser time to settle before each sample. With this spacing, every sample number inside the start, data and stop cells can be reached on purpose. The bench uses that to place single bad samples in the vote window, a stop bit cut at sample 9, and a false start pattern early in the stop bit. It also exercises enable and task-reset changes in the middle of a byte.

// File: rtl/lin_rx_pkg.sv
`timescale 1ns/1ps
package lin_rx_pkg;

  typedef enum logic [0:0] {
    RX_IDLE = 1'b0,
    RX_BUSY = 1'b1
  } rx_state_e;

  function automatic logic maj3(input logic [2:0] w);
    return (w[0] & w[1]) | (w[0] & w[2]) | (w[1] & w[2]);
  endfunction

endpackage

// File: rtl/lin_rx_sync.sv
`timescale 1ns/1ps
module lin_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  generate
    if (STAGES == 0) begin : g_bypass
      assign dout = din;
    end else begin : g_chain
      logic [STAGES-1:0] pipe;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe <= '1;
        else        pipe <= {pipe[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], din} & {STAGES{1'b1}};
      end
      assign dout = pipe[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/lin_rx_startdet.sv
`timescale 1ns/1ps
module lin_rx_startdet #(
  parameter int QUAL_LOWS = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  input  logic smp,
  output logic hit
);

  localparam int CW = (QUAL_LOWS > 1) ? $clog2(QUAL_LOWS) : 1;
  localparam logic [CW-1:0] LAST_LOW = CW'(QUAL_LOWS - 1);

  logic          armed;
  logic [CW-1:0] lowrun;

  assign hit = tick && armed && !smp && (lowrun == LAST_LOW);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      lowrun <= '0;
    end else if (clr) begin
      armed  <= 1'b0;
      lowrun <= '0;
    end else if (tick) begin
      if (smp) begin
        armed  <= 1'b1;
        lowrun <= '0;
      end else if (armed) begin
        if (lowrun == LAST_LOW) begin
          armed  <= 1'b0;
          lowrun <= '0;
        end else begin
          lowrun <= lowrun + 1'b1;
        end
      end
    end
  end

  // a completed pattern must be re-armed by a high sample before it can fire again
  assert_hit_needs_rearm_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> !hit);

endmodule

// File: rtl/lin_rx_core.sv
`timescale 1ns/1ps
module lin_rx_core
  import lin_rx_pkg::*;
#(
  parameter int DATA_BITS     = 8,
  parameter int OVERSAMPLE    = 16,
  parameter int QUAL_LOWS     = 3,
  parameter int VERIFY_SAMPLE = 7,
  parameter int VOTE_SAMPLE   = 9,
  parameter int EARLY_SAMPLE  = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick,
  input  logic                 smp,
  input  logic                 hit,
  input  logic                 en,
  output logic [DATA_BITS-1:0] data,
  output logic                 valid,
  output logic                 ferr,
  output logic                 ract
);

  localparam int SW = $clog2(OVERSAMPLE);
  localparam int BW = $clog2(DATA_BITS + 2);
  localparam logic [BW-1:0] STOP_BIT   = BW'(DATA_BITS + 1);
  localparam logic [SW-1:0] LAST_IDX   = SW'(OVERSAMPLE - 1);
  localparam logic [SW-1:0] QUAL_IDX   = SW'(QUAL_LOWS - 1);
  localparam logic [SW-1:0] VERIFY_IDX = SW'(VERIFY_SAMPLE - 1);
  localparam logic [SW-1:0] VOTE_IDX   = SW'(VOTE_SAMPLE - 1);
  localparam logic [SW-1:0] EARLY_IDX  = SW'(EARLY_SAMPLE - 1);

  rx_state_e             state;
  logic [SW-1:0]         sidx;
  logic [BW-1:0]         bitno;
  logic [2:0]            win;
  logic [DATA_BITS-1:0]  shreg;
  logic                  stop_ok;

  logic [SW-1:0] cur_idx;
  logic [BW-1:0] cur_bit;
  logic          vote;
  logic          in_data;

  always_comb begin
    cur_idx = (sidx == LAST_IDX) ? '0 : sidx + 1'b1;
    cur_bit = (sidx == LAST_IDX) ? bitno + 1'b1 : bitno;
    vote    = maj3({win[1:0], smp});
    in_data = (cur_bit != '0) && (cur_bit != STOP_BIT);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= RX_IDLE;
      sidx    <= '0;
      bitno   <= '0;
      win     <= '1;
      shreg   <= '0;
      stop_ok <= 1'b1;
      data    <= '0;
      valid   <= 1'b0;
      ferr    <= 1'b0;
      ract    <= 1'b0;
    end else begin
      valid <= 1'b0;
      ferr  <= 1'b0;
      if (tick) win <= {win[1:0], smp};
      if (!en) begin
        state <= RX_IDLE;
        ract  <= 1'b0;
      end else if (tick) begin
        case (state)
          RX_IDLE: begin
            if (hit) begin
              state <= RX_BUSY;
              sidx  <= QUAL_IDX;
              bitno <= '0;
              ract  <= 1'b1;
            end
          end
          RX_BUSY: begin
            sidx  <= cur_idx;
            bitno <= cur_bit;
            if (cur_bit == '0 && cur_idx == VERIFY_IDX && vote) begin
              state <= RX_IDLE;
              ract  <= 1'b0;
            end
            if (in_data && cur_idx == VOTE_IDX)
              shreg <= {vote, shreg[DATA_BITS-1:1]};
            if (cur_bit == STOP_BIT) begin
              if (cur_idx == VOTE_IDX) stop_ok <= vote;
              if (cur_idx >= EARLY_IDX && hit) begin
                valid <= 1'b1;
                ferr  <= !stop_ok;
                data  <= shreg;
                sidx  <= QUAL_IDX;
                bitno <= '0;
              end else if (cur_idx == LAST_IDX) begin
                valid <= 1'b1;
                ferr  <= !stop_ok;
                data  <= shreg;
                state <= RX_IDLE;
                ract  <= 1'b0;
              end
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assert_idle_when_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!ract && !valid));

  assert_active_needs_pattern_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ract) |-> $past(hit && en));

  assert_single_delivery_R6: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  assert_ferr_with_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ferr |-> valid);

endmodule

// File: rtl/lin_byte_rx.sv
`timescale 1ns/1ps
module lin_byte_rx #(
  parameter int DATA_BITS     = 8,
  parameter int OVERSAMPLE    = 16,
  parameter int SYNC_STAGES   = 2,
  parameter int QUAL_LOWS     = 3,
  parameter int VERIFY_SAMPLE = 7,
  parameter int VOTE_SAMPLE   = 9,
  parameter int EARLY_SAMPLE  = 10
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_line,
  input  logic                 sample_tick,
  input  logic                 rx_en,
  input  logic                 task_rst,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_valid,
  output logic                 rx_frame_err,
  output logic                 rx_active
);

  logic line_s;
  logic run_en;
  logic pat_hit;

  assign run_en = rx_en && !task_rst;

  lin_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (rx_line),
    .dout (line_s)
  );

  lin_rx_startdet #(.QUAL_LOWS(QUAL_LOWS)) u_start (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!run_en),
    .tick (sample_tick),
    .smp  (line_s),
    .hit  (pat_hit)
  );

  lin_rx_core #(
    .DATA_BITS    (DATA_BITS),
    .OVERSAMPLE   (OVERSAMPLE),
    .QUAL_LOWS    (QUAL_LOWS),
    .VERIFY_SAMPLE(VERIFY_SAMPLE),
    .VOTE_SAMPLE  (VOTE_SAMPLE),
    .EARLY_SAMPLE (EARLY_SAMPLE)
  ) u_core (
    .clk  (clk),
    .rst_n(rst_n),
    .tick (sample_tick),
    .smp  (line_s),
    .hit  (pat_hit),
    .en   (run_en),
    .data (rx_data),
    .valid(rx_valid),
    .ferr (rx_frame_err),
    .ract (rx_active)
  );

  assert_data_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_data));

  assert_port_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_en || task_rst) |=> !rx_active);

endmodule

// File: tb/lin_byte_rx_tb.sv
`timescale 1ns/1ps
module lin_byte_rx_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       rx_line;
  logic       sample_tick;
  logic       rx_en;
  logic       task_rst;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       rx_frame_err;
  logic       rx_active;

  always #5 clk = ~clk;

  lin_byte_rx u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_line     (rx_line),
    .sample_tick (sample_tick),
    .rx_en       (rx_en),
    .task_rst    (task_rst),
    .rx_data     (rx_data),
    .rx_valid    (rx_valid),
    .rx_frame_err(rx_frame_err),
    .rx_active   (rx_active)
  );

  int    n_cmp  = 0;
  int    n_bad  = 0;
  bit    done   = 1'b0;
  string req    = "R1";

  // behavioural reference state
  bit         model_line;
  int         hist[$];
  bit         m_busy;
  int         pos;
  int         smp[1:160];
  bit         m_stop_ok;
  logic [7:0] m_shift;
  logic [7:0] exp_data;
  bit         exp_valid, exp_ferr, exp_ract;

  task automatic model_reset();
    hist.delete();
    m_busy = 0; pos = 0; m_stop_ok = 1; m_shift = '0;
    exp_data = '0; exp_valid = 0; exp_ferr = 0; exp_ract = 0;
  endtask

  task automatic deliver();
    exp_valid = 1;
    exp_ferr  = !m_stop_ok;
    exp_data  = m_shift;
  endtask

  task automatic model_step(input bit t);
    int  v, off;
    bit  pat;
    exp_valid = 0;
    exp_ferr  = 0;
    if (!rx_en || task_rst) begin
      m_busy = 0; exp_ract = 0; hist.delete();
      return;
    end
    if (!t) return;
    v = model_line;
    hist.push_back(v);
    if (hist.size() > 4) void'(hist.pop_front());
    pat = (hist.size() == 4) && hist[0] == 1 && hist[1] == 0 && hist[2] == 0 && hist[3] == 0;
    if (!m_busy) begin
      if (pat) begin m_busy = 1; pos = 3; exp_ract = 1; end
      return;
    end
    pos++;
    smp[pos] = v;
    if (pos == 7) begin
      if (smp[5] + smp[6] + smp[7] >= 2) begin m_busy = 0; exp_ract = 0; end
    end else if (pos >= 17 && pos <= 144) begin
      off = (pos - 17) % 16 + 1;
      if (off == 9) m_shift[(pos - 17) / 16] = (smp[pos-2] + smp[pos-1] + smp[pos]) >= 2;
    end else if (pos > 144) begin
      off = pos - 144;
      if (off == 9) m_stop_ok = (smp[pos-2] + smp[pos-1] + smp[pos]) >= 2;
      if (off >= 10 && pat) begin
        deliver(); pos = 3;
      end else if (off == 16) begin
        deliver(); m_busy = 0; exp_ract = 0;
      end
    end
  endtask

  task automatic compare();
    n_cmp++;
    if (rx_valid !== exp_valid || rx_frame_err !== exp_ferr ||
        rx_active !== exp_ract || rx_data !== exp_data) begin
      n_bad++;
      $display("FAIL %s t=%0t actual v=%b fe=%b act=%b d=%02h expected v=%b fe=%b act=%b d=%02h",
               req, $time, rx_valid, rx_frame_err, rx_active, rx_data,
               exp_valid, exp_ferr, exp_ract, exp_data);
    end
  endtask

  // called at a negedge; leaves at the next negedge after comparing
  task automatic cyc(input bit t);
    sample_tick = t;
    @(posedge clk);
    #1 model_step(t);
    @(negedge clk);
    sample_tick = 1'b0;
    compare();
  endtask

  task automatic smp_n(input bit v, input int n);
    for (int i = 0; i < n; i++) begin
      rx_line = v; model_line = v;
      cyc(0); cyc(0); cyc(0); cyc(1);
    end
  endtask

  task automatic send_byte(input logic [7:0] d, input bit stop_v, input int stop_len, input bit noisy);
    smp_n(0, 16);
    for (int i = 0; i < 8; i++) begin
      if (noisy) begin
        smp_n(d[i], 6); smp_n(!d[i], 1); smp_n(d[i], 9);
      end else begin
        smp_n(d[i], 16);
      end
    end
    smp_n(stop_v, stop_len);
  endtask

  initial begin
    rst_n = 1'b0; rx_line = 1'b1; model_line = 1'b1;
    sample_tick = 1'b0; rx_en = 1'b1; task_rst = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    req = "R1";
    compare();
    smp_n(1, 8);

    req = "R2";                       // short low glitches do not qualify
    smp_n(0, 2); smp_n(1, 6); smp_n(0, 1); smp_n(1, 4);

    req = "R4";                       // plain byte, LSB first
    send_byte(8'hA5, 1, 16, 0);
    req = "R10"; smp_n(1, 20);

    req = "R4";                       // one bad sample inside each vote window
    send_byte(8'h3C, 1, 16, 1);
    req = "R6"; smp_n(1, 4);

    req = "R5";                       // stop bit low
    send_byte(8'h81, 0, 16, 0);
    smp_n(1, 6);

    req = "R3";                       // start collapses before sample 7
    smp_n(0, 4); smp_n(1, 16);

    req = "R7";                       // stop cut at sample 9, next byte follows
    send_byte(8'h5A, 1, 9, 0);
    send_byte(8'hC3, 1, 16, 0);
    smp_n(1, 4);

    req = "R8";                       // false pattern at stop samples 2..4
    send_byte(8'h0F, 1, 1, 0);
    smp_n(0, 3); smp_n(1, 12);
    smp_n(1, 4);

    req = "R9";                       // enable dropped mid-byte
    smp_n(0, 16); smp_n(1, 20);
    rx_en = 1'b0;
    smp_n(1, 10);
    rx_en = 1'b1;
    smp_n(1, 4);
    task_rst = 1'b1;                  // pattern during task reset
    smp_n(1, 2); smp_n(0, 16);
    smp_n(1, 4);
    task_rst = 1'b0;
    smp_n(1, 4);
    smp_n(0, 16); smp_n(0, 16);       // task reset mid-byte
    task_rst = 1'b1;
    smp_n(1, 4);
    task_rst = 1'b0;
    smp_n(1, 4);
    send_byte(8'h77, 1, 16, 0);
    req = "R10"; smp_n(1, 8);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog %s actual=hung expected=complete", req);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule